// File: doc/BRIEF.md
# Receive Destination Address Filter

This block screens each incoming Ethernet frame by its 48-bit destination address. The address arrives one byte per valid cycle, first byte first, after a start-of-frame strobe. While the bytes stream in, the block collects them and folds them into a CRC-32. When the sixth byte is taken, it combines the address class (broadcast, multicast or unicast) with the configuration inputs and registers an accept or reject verdict.

Multicast frames are screened through a 64-bin table. The bin index is the top six bits of a CRC-32 over the six address bytes. The register starts at all ones, uses the generator 0x04C11DB7, takes each byte least significant bit first and gets no final inversion. Unicast frames can be limited to the station address. A promiscuous enable overrides every other rule. Setting all 64 table bits accepts every multicast frame.

Top module: `rx_addr_gate`

## Requirements
- R1: `verdict_vld` is high for exactly one cycle, in the cycle after the sixth byte of a frame is taken. Bytes after the sixth are ignored until the next `sof`, and a frame yields at most one verdict.
- R2: `sof` restarts byte collection and the CRC. Both outputs are low in the cycle after `sof`. A `byte_vld` in the same cycle as `sof` is not taken as an address byte.
- R3: With `cfg_promisc` = 1, the verdict is accept for any address.
- R4: With `cfg_promisc` = 0 and the address all ones, the verdict equals `cfg_bcast_en`, whatever the hash table holds.
- R5: With `cfg_promisc` = 0 and a non-broadcast multicast address (bit 0 of the first byte is 1), the verdict is accept only if `cfg_mcast_en` = 1 and the table bit at index h is set. h is CRC bits 31:26 of the CRC-32 defined above. h[5] = 1 selects `cfg_hash_hi`, h[5] = 0 selects `cfg_hash_lo`, and h[4:0] is the bit within the selected word.
- R6: With `cfg_promisc` = 0 and `cfg_ucast_filt` = 1, a unicast address (bit 0 of the first byte is 0) is accepted only when it equals the station address. `cfg_station_hi` holds bytes 0..2 and `cfg_station_lo` holds bytes 3..5, with the earlier byte in the higher bits (byte 0 in `cfg_station_hi[23:16]`).
- R7: With `cfg_promisc` = 0 and `cfg_ucast_filt` = 0, every unicast address is accepted.
- R8: With all 64 table bits set and `cfg_mcast_en` = 1, every non-broadcast multicast address is accepted.
- R9: After reset, `verdict_vld` and `verdict_accept` are low.
- R10: `verdict_accept` is low whenever `verdict_vld` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sof | input | 1 | Start-of-frame strobe |
| byte_vld | input | 1 | Address byte valid |
| byte_data | input | 8 | Address byte, first byte first |
| cfg_station_hi | input | 24 | Station address bytes 0..2 |
| cfg_station_lo | input | 24 | Station address bytes 3..5 |
| cfg_hash_hi | input | 32 | Hash table bins 32..63 |
| cfg_hash_lo | input | 32 | Hash table bins 0..31 |
| cfg_promisc | input | 1 | Accept every frame |
| cfg_bcast_en | input | 1 | Accept broadcast |
| cfg_mcast_en | input | 1 | Accept multicast through hash table |
| cfg_ucast_filt | input | 1 | Restrict unicast to the station address |
| verdict_vld | output | 1 | One-cycle verdict strobe |
| verdict_accept | output | 1 | Accept flag, valid with `verdict_vld` |

## Verification
The bench builds the block with its default parameters: six address bytes and a six-bit hash index. These give a 64-bin table split into two 32-bit words. Random multicast addresses therefore land in bins of both words. Directed single-bin cases set or clear exactly the addressed bit, which isolates the word-select bit and the bit-within-word position. Random idle gaps between bytes, stray bytes after the sixth, and restarts in mid-frame exercise the byte counter and its saturation.

// File: rtl/rxaf_pkg.sv
package rxaf_pkg;
  localparam int OCTET = 8;

  // Fold one byte into the CRC register, least significant data bit first.
  function automatic logic [31:0] crc_step(input logic [31:0] crc_in,
                                           input logic [OCTET-1:0] data,
                                           input logic [31:0] poly);
    logic [31:0] c;
    logic        fb;
    c = crc_in;
    for (int k = 0; k < OCTET; k++) begin
      fb = c[31] ^ data[k];
      c  = {c[30:0], 1'b0} ^ (fb ? poly : 32'h0);
    end
    return c;
  endfunction
endpackage

// File: rtl/rxaf_capture.sv
module rxaf_capture #(
  parameter int ADDR_BYTES = 6
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          sof,
  input  logic                          byte_vld,
  input  logic [rxaf_pkg::OCTET-1:0]    byte_data,
  output logic                          take_byte,
  output logic                          last_byte,
  output logic [8*ADDR_BYTES-1:0]       addr_full
);
  localparam int CNT_W = $clog2(ADDR_BYTES + 1);
  localparam logic [CNT_W-1:0] CNT_DONE = CNT_W'(ADDR_BYTES);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ADDR_BYTES - 1);

  logic [CNT_W-1:0] cnt_q;

  assign take_byte = byte_vld && !sof && (cnt_q != CNT_DONE);
  assign last_byte = take_byte && (cnt_q == CNT_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt_q <= '0;
    else if (sof)       cnt_q <= '0;
    else if (take_byte) cnt_q <= cnt_q + 1'b1;
  end

  // Only the leading bytes are held; the final byte is used live.
  for (genvar i = 0; i < ADDR_BYTES - 1; i++) begin : g_hold
    logic [7:0] held_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   held_q <= '0;
      else if (take_byte && cnt_q == CNT_W'(i))     held_q <= byte_data;
    end
    assign addr_full[8*(ADDR_BYTES-i)-1 -: 8] = held_q;
  end
  assign addr_full[7:0] = byte_data;
endmodule

// File: rtl/rxaf_crc.sv
module rxaf_crc #(
  parameter logic [31:0] POLY = 32'h04C1_1DB7,
  parameter logic [31:0] INIT = 32'hFFFF_FFFF
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       sof,
  input  logic                       take_byte,
  input  logic [rxaf_pkg::OCTET-1:0] byte_data,
  output logic [31:0]                crc_next
);
  logic [31:0] crc_q;

  assign crc_next = rxaf_pkg::crc_step(crc_q, byte_data, POLY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         crc_q <= INIT;
    else if (sof)       crc_q <= INIT;
    else if (take_byte) crc_q <= crc_next;
  end
endmodule

// File: rtl/rxaf_classify.sv
module rxaf_classify #(
  parameter int ADDR_BYTES = 6,
  parameter int HASH_BITS  = 6,
  localparam int ADDR_W  = 8 * ADDR_BYTES,
  localparam int HALF_W  = ADDR_W / 2,
  localparam int TABLE_W = 1 << HASH_BITS,
  localparam int WORD_W  = TABLE_W / 2
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       crc,
  input  logic [HALF_W-1:0] station_hi,
  input  logic [HALF_W-1:0] station_lo,
  input  logic [WORD_W-1:0] hash_hi,
  input  logic [WORD_W-1:0] hash_lo,
  input  logic              promisc,
  input  logic              bcast_en,
  input  logic              mcast_en,
  input  logic              ucast_filt,
  output logic              is_bcast,
  output logic              is_mcast,
  output logic              station_hit,
  output logic              hash_hit,
  output logic              accept
);
  logic [HASH_BITS-1:0] bin;
  logic [TABLE_W-1:0]   table_all;

  assign bin         = crc[31 -: HASH_BITS];
  assign table_all   = {hash_hi, hash_lo};
  assign hash_hit    = table_all[bin];
  assign is_bcast    = &addr;
  assign is_mcast    = addr[ADDR_W-8];
  assign station_hit = (addr == {station_hi, station_lo});

  always_comb begin
    if (promisc)       accept = 1'b1;
    else if (is_bcast) accept = bcast_en;
    else if (is_mcast) accept = mcast_en && hash_hit;
    else               accept = !ucast_filt || station_hit;
  end
endmodule

// File: rtl/rx_addr_gate.sv
module rx_addr_gate #(
  parameter int ADDR_BYTES = 6,
  parameter int HASH_BITS  = 6,
  localparam int HALF_W = 4 * ADDR_BYTES,
  localparam int WORD_W = (1 << HASH_BITS) / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sof,
  input  logic              byte_vld,
  input  logic [7:0]        byte_data,
  input  logic [HALF_W-1:0] cfg_station_hi,
  input  logic [HALF_W-1:0] cfg_station_lo,
  input  logic [WORD_W-1:0] cfg_hash_hi,
  input  logic [WORD_W-1:0] cfg_hash_lo,
  input  logic              cfg_promisc,
  input  logic              cfg_bcast_en,
  input  logic              cfg_mcast_en,
  input  logic              cfg_ucast_filt,
  output logic              verdict_vld,
  output logic              verdict_accept
);
  logic                    take_byte;
  logic                    last_byte_evt;
  logic [8*ADDR_BYTES-1:0] addr_full;
  logic [31:0]             crc_next;
  logic                    is_bcast, is_mcast, station_hit, hash_hit, accept_now;

  rxaf_capture #(.ADDR_BYTES(ADDR_BYTES)) u_capture (
    .clk(clk), .rst_n(rst_n), .sof(sof), .byte_vld(byte_vld),
    .byte_data(byte_data), .take_byte(take_byte),
    .last_byte(last_byte_evt), .addr_full(addr_full)
  );

  rxaf_crc u_crc (
    .clk(clk), .rst_n(rst_n), .sof(sof), .take_byte(take_byte),
    .byte_data(byte_data), .crc_next(crc_next)
  );

  rxaf_classify #(.ADDR_BYTES(ADDR_BYTES), .HASH_BITS(HASH_BITS)) u_classify (
    .addr(addr_full), .crc(crc_next),
    .station_hi(cfg_station_hi), .station_lo(cfg_station_lo),
    .hash_hi(cfg_hash_hi), .hash_lo(cfg_hash_lo),
    .promisc(cfg_promisc), .bcast_en(cfg_bcast_en),
    .mcast_en(cfg_mcast_en), .ucast_filt(cfg_ucast_filt),
    .is_bcast(is_bcast), .is_mcast(is_mcast),
    .station_hit(station_hit), .hash_hit(hash_hit), .accept(accept_now)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      verdict_vld    <= 1'b0;
      verdict_accept <= 1'b0;
    end else begin
      verdict_vld    <= last_byte_evt;
      verdict_accept <= last_byte_evt && accept_now;
    end
  end
endmodule

// File: rtl/rx_addr_gate_chk.sv
module rx_addr_gate_chk (
  input logic clk,
  input logic rst_n,
  input logic sof,
  input logic cfg_promisc,
  input logic cfg_bcast_en,
  input logic cfg_mcast_en,
  input logic cfg_ucast_filt,
  input logic verdict_vld,
  input logic verdict_accept,
  input logic last_byte_evt,
  input logic is_bcast,
  input logic is_mcast,
  input logic station_hit,
  input logic hash_hit
);
  assert_pulse_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
    verdict_vld |=> !verdict_vld);

  assert_vld_after_last_R1: assert property (@(posedge clk) disable iff (!rst_n)
    last_byte_evt |=> verdict_vld);

  assert_sof_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sof |=> !verdict_vld && !verdict_accept);

  assert_promisc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (last_byte_evt && cfg_promisc) |=> verdict_accept);

  assert_bcast_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (last_byte_evt && !cfg_promisc && is_bcast) |=> (verdict_accept == $past(cfg_bcast_en)));

  assert_mcast_hash_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (last_byte_evt && !cfg_promisc && !is_bcast && is_mcast)
      |=> (verdict_accept == ($past(cfg_mcast_en) && $past(hash_hit))));

  assert_ucast_filter_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (last_byte_evt && !cfg_promisc && !is_mcast && cfg_ucast_filt)
      |=> (verdict_accept == $past(station_hit)));

  assert_ucast_open_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (last_byte_evt && !cfg_promisc && !is_mcast && !cfg_ucast_filt) |=> verdict_accept);

  assert_accept_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !verdict_vld |-> !verdict_accept);
endmodule

bind rx_addr_gate rx_addr_gate_chk u_chk (.*);

// File: tb/rx_addr_gate_tb.sv
`timescale 1ns/1ps
module rx_addr_gate_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sof = 1'b0;
  logic        byte_vld = 1'b0;
  logic [7:0]  byte_data = '0;
  logic [23:0] st_hi = '0, st_lo = '0;
  logic [31:0] hs_hi = '0, hs_lo = '0;
  logic        promisc = 0, bcast_en = 0, mcast_en = 0, ucast_filt = 0;
  logic        verdict_vld, verdict_accept;

  int nchecks = 0;
  int nfails  = 0;

  always #5 clk = ~clk;

  rx_addr_gate u_dut (
    .clk(clk), .rst_n(rst_n), .sof(sof), .byte_vld(byte_vld), .byte_data(byte_data),
    .cfg_station_hi(st_hi), .cfg_station_lo(st_lo),
    .cfg_hash_hi(hs_hi), .cfg_hash_lo(hs_lo),
    .cfg_promisc(promisc), .cfg_bcast_en(bcast_en),
    .cfg_mcast_en(mcast_en), .cfg_ucast_filt(ucast_filt),
    .verdict_vld(verdict_vld), .verdict_accept(verdict_accept)
  );

  // Bit-serial restatement over the whole 48-bit address.
  function automatic logic [5:0] bin_of(input logic [47:0] a);
    logic [31:0] r = 32'hFFFF_FFFF;
    for (int n = 0; n < 48; n++) begin
      logic b;
      b = a[40 - 8*(n/8) + (n%8)];
      if (r[31] ^ b) r = (r << 1) ^ 32'h04C1_1DB7;
      else           r = r << 1;
    end
    return r[31:26];
  endfunction

  function automatic logic expect_accept(input logic [47:0] a);
    logic [63:0] t;
    t = {hs_hi, hs_lo};
    if (promisc)       return 1'b1;
    if (a == '1)       return bcast_en;
    if (a[40])         return mcast_en && t[bin_of(a)];
    if (ucast_filt)    return a == {st_hi, st_lo};
    return 1'b1;
  endfunction

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    nchecks++;
    if (got !== exp) begin
      nfails++;
      $display("FAIL %s got=%0h expected=%0h", req, got, exp);
    end
  endtask

  task automatic report;
    $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfails);
    $finish;
  endtask

  // Leaves the bench at the falling edge where the verdict is visible.
  task automatic send_addr(input logic [47:0] a, input int gap_max, input bit junk_on_sof);
    @(negedge clk);
    sof = 1'b1;
    byte_vld = junk_on_sof;
    byte_data = junk_on_sof ? 8'h01 : 8'h00;
    @(negedge clk);
    sof = 1'b0;
    byte_vld = 1'b0;
    check("R2 cleared after sof", {verdict_vld, verdict_accept}, 2'b00);
    for (int i = 0; i < 6; i++) begin
      if (gap_max > 0) begin
        byte_vld = 1'b0;
        repeat ($urandom_range(gap_max, 0)) @(negedge clk);
      end
      byte_vld = 1'b1;
      byte_data = a[47-8*i -: 8];
      @(negedge clk);
    end
    byte_vld = 1'b0;
  endtask

  task automatic check_frame(input string req, input logic [47:0] a, input int gap_max);
    logic e;
    e = expect_accept(a);
    send_addr(a, gap_max, 1'b0);
    check({req, " verdict strobe R1"}, verdict_vld, 1'b1);
    check({req, " decision"}, verdict_accept, e);
    @(negedge clk);
    check({req, " single pulse R1 / R10"}, {verdict_vld, verdict_accept}, 2'b00);
  endtask

  function automatic logic [47:0] rand_mcast();
    logic [47:0] a;
    a = {$urandom, $urandom};
    a[40] = 1'b1;
    if (a == '1) a[0] = 1'b0;
    return a;
  endfunction

  function automatic logic [47:0] rand_ucast();
    logic [47:0] a;
    a = {$urandom, $urandom};
    a[40] = 1'b0;
    return a;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    nfails++;
    $display("FAIL watchdog expired got=0 expected=1");
    report();
  end

  initial begin
    logic [47:0] a, b;
    logic [5:0]  h;
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    check("R9 reset outputs", {verdict_vld, verdict_accept}, 2'b00);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 after reset release", {verdict_vld, verdict_accept}, 2'b00);

    st_hi = 24'h02_A1_B2; st_lo = 24'hC3_D4_E5;
    ucast_filt = 1'b1;
    check_frame("R6 station match", {st_hi, st_lo}, 0);
    check_frame("R6 station mismatch", {st_hi, st_lo ^ 24'h000100}, 0);
    check_frame("R6 first byte differs", {st_hi ^ 24'h100000, st_lo}, 2);
    ucast_filt = 1'b0;
    check_frame("R7 any unicast", rand_ucast(), 1);

    bcast_en = 1'b1; hs_hi = '0; hs_lo = '0;
    check_frame("R4 broadcast on", '1, 0);
    bcast_en = 1'b0; hs_hi = '1; hs_lo = '1; mcast_en = 1'b1;
    check_frame("R4 broadcast off ignores table", '1, 0);

    promisc = 1'b1; ucast_filt = 1'b1; mcast_en = 1'b0; hs_hi = '0; hs_lo = '0;
    check_frame("R3 promisc broadcast", '1, 0);
    check_frame("R3 promisc unicast", rand_ucast(), 1);
    check_frame("R3 promisc multicast", rand_mcast(), 1);
    promisc = 1'b0;

    mcast_en = 1'b1; hs_hi = '1; hs_lo = '1;
    for (int k = 0; k < 20; k++) check_frame("R8 all bins", rand_mcast(), 2);
    mcast_en = 1'b0;
    check_frame("R5 multicast disabled", rand_mcast(), 0);

    mcast_en = 1'b1;
    for (int k = 0; k < 12; k++) begin
      a = rand_mcast();
      h = bin_of(a);
      {hs_hi, hs_lo} = 64'd1 << h;
      check_frame("R5 single bin set", a, 1);
      {hs_hi, hs_lo} = ~(64'd1 << h);
      check_frame("R5 single bin clear", a, 0);
    end

    // Bytes after the sixth are ignored.
    ucast_filt = 1'b0;
    send_addr(rand_ucast(), 0, 1'b0);
    check("R1 verdict before extras", verdict_vld, 1'b1);
    for (int k = 0; k < 4; k++) begin
      byte_vld = 1'b1; byte_data = 8'($urandom);
      @(negedge clk);
      check("R1 no verdict from extra byte", {verdict_vld, verdict_accept}, 2'b00);
    end
    byte_vld = 1'b0;

    // Restart mid-frame, then a byte on the sof cycle.
    ucast_filt = 1'b1;
    a = rand_mcast();
    @(negedge clk); sof = 1'b1;
    @(negedge clk); sof = 1'b0;
    for (int i = 0; i < 3; i++) begin
      byte_vld = 1'b1; byte_data = a[47-8*i -: 8]; @(negedge clk);
    end
    byte_vld = 1'b0;
    check_frame("R2 restart mid-frame", {st_hi, st_lo}, 0);
    send_addr({st_hi, st_lo}, 0, 1'b1);
    check("R2 byte on sof ignored strobe", verdict_vld, 1'b1);
    check("R2 byte on sof ignored decision", verdict_accept, 1'b1);
    @(negedge clk);

    for (int k = 0; k < 400; k++) begin
      promisc    = ($urandom_range(7, 0) == 0);
      bcast_en   = 1'($urandom);
      mcast_en   = 1'($urandom);
      ucast_filt = 1'($urandom);
      hs_hi = $urandom; hs_lo = $urandom;
      st_hi = 24'($urandom); st_lo = 24'($urandom); st_hi[16] = 1'b0;
      case ($urandom_range(3, 0))
        0: b = {st_hi, st_lo};
        1: b = '1;
        2: b = rand_mcast();
        default: b = rand_ucast();
      endcase
      check_frame("R3-R7 random mix", b, 2);
    end

    report();
  end
endmodule